// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that carries a device through a one-time change of its lifecycle state. A transition runs as a fixed chain of steps. A clock switch comes first. Then the transition counter is incremented and programmed, and the requested transition is checked for validity. The unlock token is hashed, an optional flash RMA step runs, and the token is compared in two halves. Last, the new state is programmed. Every step that can fail drops the machine into a terminal post-transition state and raises a sticky abort flag.

Each step is driven through a registered enable strobe. Its outcome comes back on a shared acknowledge/error pair, since only one step is active at a time. An idle device may instead be sent straight to a scrap state. Two independent escalation inputs override every other decision and force a sticky escalate state.

The state register uses sparse codes. Any value outside the legal set is treated as a fault: the machine moves to an invalid state and a sticky fatal error is raised. The real hash engine, one-time-programmable memory, flash and clock mux are outside the block and are reached only through the strobes and handshake inputs.

Top module: `lcx_sequencer`

## Requirements
- R1: `rst` is a synchronous, active-high reset. While it is high, `state_o` holds the Reset code and all other outputs are 0. On the first clock edge after release, the state becomes Idle.
- R2: In Idle, `trans_req_i` moves the machine to ClkMux. From ClkMux, each cycle with `step_ack_i` high advances one state along ClkMux, CntIncr, CntProg, TransCheck, TokenHash, FlashRma, TokenCheck0. Without an acknowledge, the state holds.
- R3: In CntIncr, CntProg, TransCheck and TokenHash, `step_err_i` sends the machine to PostTrans and sets `abort_o`. The error wins over a simultaneous acknowledge. In ClkMux and FlashRma, `step_err_i` has no effect.
- R4: TokenCheck0 advances to TokenCheck1 when `tok_match_i[0]` is 1. TokenCheck1 advances to TransProg when both bits of `tok_match_i` are 1. Otherwise either state goes to PostTrans with `abort_o` set. Each decides in a single cycle, so neither state lasts more than one cycle.
- R5: TransProg always ends in PostTrans. It goes there with `abort_o` left at 0 on `step_ack_i`, and with `abort_o` set on `step_err_i`.
- R6: In Idle, `scrap_req_i` moves the machine to Scrap and takes priority over `trans_req_i`.
- R7: When `esc0_i` or `esc1_i` is high, every state from Idle through PostTrans, and the Invalid state, goes to Escalate on the next edge. This overrides every other next-state decision. Reset and Scrap do not react to escalation.
- R8: PostTrans, Scrap, Escalate and Invalid hold until reset. The one exception is the escalation arc of R7.
- R9: State codes are 7 bits. State number n is coded {n[3:0], n[1]^n[2]^n[3], n[0]^n[2]^n[3], n[0]^n[1]^n[3]}. The numbering is Reset=1, Idle=2, ClkMux=3, CntIncr=4, CntProg=5, TransCheck=6, TokenHash=7, FlashRma=8, TokenCheck0=9, TokenCheck1=10, TransProg=11, PostTrans=12, Scrap=13, Escalate=14, Invalid=15. Any other register value, including every single-bit corruption of a legal code, sets the sticky `fatal_err_o` on the next edge and leads to Invalid.
- R10: `step_en_o[k]` is 1 exactly while the state is number k+3 (ClkMux for k=0 up to TransProg for k=8). At most one bit is ever set.
- R11: `esc_active_o` is 1 exactly while the state is Escalate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trans_req_i | input | 1 | Start a lifecycle transition (sampled in Idle) |
| scrap_req_i | input | 1 | Scrap the device (sampled in Idle) |
| step_ack_i | input | 1 | Active step finished successfully |
| step_err_i | input | 1 | Active step failed |
| tok_match_i | input | 2 | Hashed token compare result, one bit per half |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| state_o | output | 7 | Current sparse state code |
| step_en_o | output | 9 | One-hot enable of the active step |
| abort_o | output | 1 | Sticky: transition aborted into PostTrans |
| esc_active_o | output | 1 | Machine is in Escalate |
| fatal_err_o | output | 1 | Sticky: illegal state encoding seen |

## Verification
The hardest situation to reach from the ports is an illegal state encoding. The code space is sparse, so no legal input sequence can ever produce one. The bench forces the state register to an all-zero value and to a single-bit corruption of the Idle code for one clock edge, then releases it. It checks that the fatal flag rises and that the machine settles in Invalid, and that escalation can still leave Invalid. Reaching TokenCheck1 and TransProg needs the full chain of acknowledges, so a helper walks the handshake step by step before each late-stage abort is injected.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
  localparam int IDX_W      = 4;
  localparam int CODE_W     = IDX_W + 3;
  localparam int FIRST_STEP = 3;
  localparam int LAST_STEP  = 11;
  localparam int NUM_STEPS  = LAST_STEP - FIRST_STEP + 1;
  localparam int TOK_PARTS  = 2;

  typedef logic [CODE_W-1:0] code_t;

  // Hamming(7,4) codeword: any two distinct codes differ in 3 or more bits
  function automatic code_t enc(input logic [IDX_W-1:0] n);
    return {n, n[1]^n[2]^n[3], n[0]^n[2]^n[3], n[0]^n[1]^n[3]};
  endfunction

  // Returns the state number, or 0 when the code is not legal
  function automatic logic [IDX_W-1:0] dec(input code_t c);
    logic [IDX_W-1:0] n;
    n = c[CODE_W-1:3];
    if (n != '0 && enc(n) == c) return n;
    return '0;
  endfunction

  localparam code_t S_RESET  = enc(4'd1);
  localparam code_t S_IDLE   = enc(4'd2);
  localparam code_t S_CLKMUX = enc(4'd3);
  localparam code_t S_CNTINC = enc(4'd4);
  localparam code_t S_CNTPRG = enc(4'd5);
  localparam code_t S_TRCHK  = enc(4'd6);
  localparam code_t S_HASH   = enc(4'd7);
  localparam code_t S_FLASH  = enc(4'd8);
  localparam code_t S_TOK0   = enc(4'd9);
  localparam code_t S_TOK1   = enc(4'd10);
  localparam code_t S_PROG   = enc(4'd11);
  localparam code_t S_POST   = enc(4'd12);
  localparam code_t S_SCRAP  = enc(4'd13);
  localparam code_t S_ESC    = enc(4'd14);
  localparam code_t S_INVAL  = enc(4'd15);
endpackage

// File: rtl/lcx_next_state.sv
module lcx_next_state
  import lcx_pkg::*;
(
  input  code_t                cur,
  input  logic                 trans_req,
  input  logic                 scrap_req,
  input  logic                 ack,
  input  logic                 err,
  input  logic [TOK_PARTS-1:0] tok_match,
  input  logic                 esc,
  output code_t                nxt,
  output logic                 abort_set,
  output logic                 legal
);
  logic esc_reacts;

  assign legal      = (dec(cur) != '0);
  assign esc_reacts = legal && (cur != S_RESET) && (cur != S_SCRAP);

  always_comb begin
    nxt       = cur;
    abort_set = 1'b0;
    case (cur)
      S_RESET:  nxt = S_IDLE;
      S_IDLE: begin
        if (scrap_req)      nxt = S_SCRAP;
        else if (trans_req) nxt = S_CLKMUX;
      end
      S_CLKMUX: if (ack) nxt = S_CNTINC;
      S_CNTINC: begin
        if (err)      begin nxt = S_POST; abort_set = 1'b1; end
        else if (ack) nxt = S_CNTPRG;
      end
      S_CNTPRG: begin
        if (err)      begin nxt = S_POST; abort_set = 1'b1; end
        else if (ack) nxt = S_TRCHK;
      end
      S_TRCHK: begin
        if (err)      begin nxt = S_POST; abort_set = 1'b1; end
        else if (ack) nxt = S_HASH;
      end
      S_HASH: begin
        if (err)      begin nxt = S_POST; abort_set = 1'b1; end
        else if (ack) nxt = S_FLASH;
      end
      S_FLASH:  if (ack) nxt = S_TOK0;
      S_TOK0: begin
        if (tok_match[0]) nxt = S_TOK1;
        else begin nxt = S_POST; abort_set = 1'b1; end
      end
      S_TOK1: begin
        if (&tok_match) nxt = S_PROG;
        else begin nxt = S_POST; abort_set = 1'b1; end
      end
      S_PROG: begin
        if (err)      begin nxt = S_POST; abort_set = 1'b1; end
        else if (ack) nxt = S_POST;
      end
      S_POST, S_SCRAP, S_ESC, S_INVAL: nxt = cur;
      default:  nxt = S_INVAL;
    endcase
    if (esc && esc_reacts) begin
      nxt       = S_ESC;
      abort_set = 1'b0;
    end
  end
endmodule

// File: rtl/lcx_out_reg.sv
module lcx_out_reg
  import lcx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  code_t                nxt,
  input  logic                 abort_set,
  input  logic                 legal,
  output logic [NUM_STEPS-1:0] step_en_o,
  output logic                 abort_o,
  output logic                 esc_active_o,
  output logic                 fatal_err_o
);
  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    always_ff @(posedge clk) begin
      if (rst) step_en_o[k] <= 1'b0;
      else     step_en_o[k] <= (nxt == enc(IDX_W'(FIRST_STEP + k)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_o      <= 1'b0;
      esc_active_o <= 1'b0;
      fatal_err_o  <= 1'b0;
    end else begin
      abort_o      <= abort_o | abort_set;
      esc_active_o <= (nxt == S_ESC);
      fatal_err_o  <= fatal_err_o | ~legal;
    end
  end

  // R10
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_en_o));

  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_err_o |=> fatal_err_o);
endmodule

// File: rtl/lcx_sequencer.sv
module lcx_sequencer
  import lcx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trans_req_i,
  input  logic                 scrap_req_i,
  input  logic                 step_ack_i,
  input  logic                 step_err_i,
  input  logic [TOK_PARTS-1:0] tok_match_i,
  input  logic                 esc0_i,
  input  logic                 esc1_i,
  output logic [CODE_W-1:0]    state_o,
  output logic [NUM_STEPS-1:0] step_en_o,
  output logic                 abort_o,
  output logic                 esc_active_o,
  output logic                 fatal_err_o
);
  code_t state_q;
  code_t nxt;
  logic  abort_set;
  logic  legal;

  lcx_next_state u_next (
    .cur       (state_q),
    .trans_req (trans_req_i),
    .scrap_req (scrap_req_i),
    .ack       (step_ack_i),
    .err       (step_err_i),
    .tok_match (tok_match_i),
    .esc       (esc0_i | esc1_i),
    .nxt       (nxt),
    .abort_set (abort_set),
    .legal     (legal)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_RESET;
    else     state_q <= nxt;
  end

  assign state_o = state_q;

  lcx_out_reg u_out (
    .clk          (clk),
    .rst          (rst),
    .nxt          (nxt),
    .abort_set    (abort_set),
    .legal        (legal),
    .step_en_o    (step_en_o),
    .abort_o      (abort_o),
    .esc_active_o (esc_active_o),
    .fatal_err_o  (fatal_err_o)
  );

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state_q == S_RESET);

  // R7
  esc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((esc0_i || esc1_i) && legal && state_q != S_RESET && state_q != S_SCRAP)
      |=> state_q == S_ESC);

  // R8
  post_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == S_POST |=> (state_q == S_POST || state_q == S_ESC));

  // R8
  scrap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == S_SCRAP |=> state_q == S_SCRAP);

  // R4
  tok1_once_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == S_TOK1 |=> state_q != S_TOK1);

  // R9
  illegal_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    !legal |=> fatal_err_o);

  // R11
  esc_flag_chk: assert property (@(posedge clk) disable iff (rst)
    esc_active_o == (state_o == S_ESC));
endmodule

// File: tb/tb_lcx_sequencer.sv
module tb_lcx_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trans_req_i = 1'b0, scrap_req_i = 1'b0;
  logic       step_ack_i = 1'b0, step_err_i = 1'b0;
  logic [1:0] tok_match_i = 2'b00;
  logic       esc0_i = 1'b0, esc1_i = 1'b0;
  logic [6:0] state_o;
  logic [8:0] step_en_o;
  logic       abort_o, esc_active_o, fatal_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcx_sequencer dut (
    .clk(clk), .rst(rst), .trans_req_i(trans_req_i), .scrap_req_i(scrap_req_i),
    .step_ack_i(step_ack_i), .step_err_i(step_err_i), .tok_match_i(tok_match_i),
    .esc0_i(esc0_i), .esc1_i(esc1_i), .state_o(state_o), .step_en_o(step_en_o),
    .abort_o(abort_o), .esc_active_o(esc_active_o), .fatal_err_o(fatal_err_o)
  );

  function automatic logic [6:0] code(input int n);
    logic [3:0] d;
    d = n[3:0];
    return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    trans_req_i = 0; scrap_req_i = 0; step_ack_i = 0; step_err_i = 0;
    tok_match_i = 2'b00; esc0_i = 0; esc1_i = 0;
  endtask

  task automatic reset_dut();
    clear_inputs();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  // walk from Idle up to state n (3..11) with good handshakes
  task automatic advance_to(input int n);
    reset_dut();
    trans_req_i = 1;
    @(negedge clk);
    trans_req_i = 0;
    for (int s = 3; s < n; s++) begin
      if (s <= 8) step_ack_i = 1;
      else        tok_match_i = 2'b11;
      @(negedge clk);
      step_ack_i = 0;
    end
    chk("R2 walk", state_o, code(n));
  endtask

  task automatic t_reset();
    clear_inputs();
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset state", state_o, code(1));
    chk("R1 reset outputs", {step_en_o, abort_o, esc_active_o, fatal_err_o}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 to idle", state_o, code(2));
  endtask

  task automatic t_pass();
    reset_dut();
    trans_req_i = 1;
    @(negedge clk);
    trans_req_i = 0;
    chk("R2 clkmux", state_o, code(3));
    chk("R10 clkmux strobe", step_en_o, 9'h001);
    @(negedge clk);
    chk("R2 hold without ack", state_o, code(3));
    step_err_i = 1;
    @(negedge clk);
    step_err_i = 0;
    chk("R3 err ignored in clkmux", state_o, code(3));
    for (int s = 4; s <= 9; s++) begin
      step_ack_i = 1;
      @(negedge clk);
      step_ack_i = 0;
      chk("R2 step", state_o, code(s));
      chk("R10 strobe", step_en_o, 1 << (s - 3));
    end
    tok_match_i = 2'b11;
    @(negedge clk);
    chk("R4 tok1 reached", state_o, code(10));
    @(negedge clk);
    chk("R4 tok1 single cycle", state_o, code(11));
    chk("R10 prog strobe", step_en_o, 9'h100);
    tok_match_i = 2'b00;
    step_ack_i = 1;
    @(negedge clk);
    step_ack_i = 0;
    chk("R5 prog ok", state_o, code(12));
    chk("R5 no abort", abort_o, 0);
    chk("R10 no strobe in post", step_en_o, 0);
    trans_req_i = 1; step_ack_i = 1;
    repeat (3) @(negedge clk);
    clear_inputs();
    chk("R8 post holds", state_o, code(12));
  endtask

  task automatic t_abort();
    for (int st = 4; st <= 7; st++) begin
      advance_to(st);
      step_err_i = 1; step_ack_i = 1;
      @(negedge clk);
      clear_inputs();
      chk("R3 abort state", state_o, code(12));
      chk("R3 abort flag", abort_o, 1);
    end
    advance_to(8);
    step_err_i = 1;
    @(negedge clk);
    step_err_i = 0;
    chk("R3 err ignored in flash", state_o, code(8));
    chk("R3 no abort in flash", abort_o, 0);
  endtask

  task automatic t_token();
    advance_to(9);
    tok_match_i = 2'b10;
    @(negedge clk);
    chk("R4 tok0 mismatch", state_o, code(12));
    chk("R4 tok0 abort", abort_o, 1);
    advance_to(10);
    tok_match_i = 2'b01;
    @(negedge clk);
    chk("R4 tok1 mismatch", state_o, code(12));
    chk("R4 tok1 abort", abort_o, 1);
  endtask

  task automatic t_prog_err();
    advance_to(11);
    tok_match_i = 2'b00;
    step_err_i = 1; step_ack_i = 1;
    @(negedge clk);
    clear_inputs();
    chk("R5 prog err", state_o, code(12));
    chk("R5 prog abort", abort_o, 1);
  endtask

  task automatic t_scrap();
    reset_dut();
    scrap_req_i = 1; trans_req_i = 1;
    @(negedge clk);
    clear_inputs();
    chk("R6 scrap priority", state_o, code(13));
    esc0_i = 1;
    repeat (2) @(negedge clk);
    esc0_i = 0;
    chk("R7 scrap ignores escalation", state_o, code(13));
    chk("R8 scrap holds", esc_active_o, 0);
  endtask

  task automatic t_esc();
    clear_inputs();
    rst = 1;
    esc1_i = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 reset state ignores escalation", state_o, code(2));
    @(negedge clk);
    esc1_i = 0;
    chk("R7 idle escalates", state_o, code(14));
    chk("R11 esc flag", esc_active_o, 1);
    trans_req_i = 1;
    repeat (2) @(negedge clk);
    trans_req_i = 0;
    chk("R8 escalate holds", state_o, code(14));
    advance_to(7);
    step_ack_i = 1; esc0_i = 1;
    @(negedge clk);
    clear_inputs();
    chk("R7 escalation beats ack", state_o, code(14));
    chk("R7 no abort on escalation", abort_o, 0);
    advance_to(4);
    step_err_i = 1;
    @(negedge clk);
    step_err_i = 0;
    esc1_i = 1;
    @(negedge clk);
    esc1_i = 0;
    chk("R7 post escalates", state_o, code(14));
    chk("R11 esc flag from post", esc_active_o, 1);
  endtask

  task automatic t_illegal(input logic [6:0] bad);
    reset_dut();
    chk("R9 legal before fault", fatal_err_o, 0);
    force dut.state_q = bad;
    @(negedge clk);
    chk("R9 fatal raised", fatal_err_o, 1);
    chk("R10 no strobe on fault", step_en_o, 0);
    release dut.state_q;
    @(negedge clk);
    chk("R9 goes invalid", state_o, code(15));
    trans_req_i = 1; step_ack_i = 1;
    repeat (2) @(negedge clk);
    clear_inputs();
    chk("R8 invalid holds", state_o, code(15));
    chk("R9 fatal sticky", fatal_err_o, 1);
    esc0_i = 1;
    @(negedge clk);
    esc0_i = 0;
    chk("R7 invalid escalates", state_o, code(14));
  endtask

  initial begin
    t_reset();
    t_pass();
    t_abort();
    t_token();
    t_prog_err();
    t_scrap();
    t_esc();
    t_illegal(7'h00);
    t_illegal(code(2) ^ 7'h04);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule